// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches the synchronized SMBus clock line and measures how long it has stayed low without a break. The measurement uses a millisecond tick that a programmable divider derives from the free-running system clock. Any high sample on the clock line restarts both the divider and the millisecond count. A low phase of normal length, such as the 50 us low half of a 10 kHz bus clock, ends long before the first deadline and has no effect.

The block has two deadlines, each counted from the first low sample. When the clock line has been low for 25 ms, the block sets a sticky timeout flag. What else it does depends on the role selected. In master role it pulses a request that the protocol engine issue a STOP. In slave role it pulses a one-cycle reset, which makes the neighbouring logic release its SDA and SCL pull-downs and wait for a new START. That reset therefore falls well inside the 35 ms window that a slave has to recover in. If the line is still low at 35 ms, a master repeats its STOP request and a slave receives nothing further. After 35 ms the count holds, so a single low phase never produces more actions.

The flag stays set until software pulses the clear input or the next START condition is seen on the bus.

Top module: `smb_scl_lowwatch`

## Requirements
- R1: After reset, tmo_flag_o, stop_req_o and slv_rst_o are all 0.
- R2: One high sample on scl_i restarts the low-time measurement. If scl_i is low for 25*(P+1)-1 cycles, high for 1 cycle, then low for 25*(P+1)-1 cycles, tmo_flag_o never rises (P is prescale_i).
- R3: One millisecond tick lasts prescale_i+1 system cycles. Count the clock edges at which scl_i is low without a break, starting at 1. tmo_flag_o is 1 after edge 25*(P+1) and 0 before it.
- R4: Past 35*(P+1) low edges, the count stays at its limit and no further stop_req_o or slv_rst_o pulse occurs while scl_i stays low.
- R5: With master_mode_i = 1, stop_req_o is a one-cycle pulse. It is high after exactly edge 25*(P+1), the same edge at which the flag rises.
- R6: With master_mode_i = 1, stop_req_o pulses again for one cycle after edge 35*(P+1) if scl_i is still low.
- R7: With master_mode_i = 0, slv_rst_o is a one-cycle pulse after edge 25*(P+1), and there is no pulse at 35*(P+1). stop_req_o stays 0 in slave role, and slv_rst_o stays 0 in master role.
- R8: tmo_flag_o stays 1 after scl_i returns high. It goes to 0 one cycle after a one-cycle pulse on tmo_clear_i.
- R9: A START is sda_i going from 1 to 0 while scl_i is 1 on both samples. It clears tmo_flag_o at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SMBus clock line |
| sda_i | input | 1 | Synchronized SMBus data line |
| master_mode_i | input | 1 | 1 = master role, 0 = slave role |
| prescale_i | input | PRESC_W | Divider value; tick period is prescale_i+1 cycles |
| tmo_clear_i | input | 1 | Software clear of the timeout flag |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| stop_req_o | output | 1 | One-cycle request to issue a STOP (master role) |
| slv_rst_o | output | 1 | One-cycle release-and-rearm reset (slave role) |

## Verification
Several properties are checked on every cycle:
- a high clock sample empties the millisecond count;
- the count only holds or steps by one, and never passes the 35 ms limit;
- both action pulses last one cycle and never occur together;
- the flag holds unless it is cleared or a START is seen.

Only the bench scenarios can show the exact edge at which each deadline acts for a given divider value. The bench sweeps the divider over small values in both roles. It also shows that a single high sample between two near-threshold low phases stops the flag from rising, and it exercises both ways of clearing the flag.

// File: rtl/smb_lw_pkg.sv
package smb_lw_pkg;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } smb_role_e;

   typedef struct packed {
      logic hit_tmo;    // low time has just reached the first deadline
      logic hit_recov;  // low time has just reached the second deadline
   } smb_lw_evt_t;

endpackage

// File: rtl/smb_lw_tick.sv
module smb_lw_tick #(
   parameter int PRESC_W = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic [PRESC_W-1:0] prescale_i,
   output logic               tick_o
);

   logic [PRESC_W-1:0] div_q;
   logic               wrap;

   assign wrap   = (div_q >= prescale_i);
   assign tick_o = !scl_i && wrap;

   // the divider restarts whenever the clock line is seen high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (scl_i || wrap)
         div_q <= '0;
      else
         div_q <= div_q + 1'b1;
   end

   AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      scl_i |=> (div_q == '0)); // R2

endmodule

// File: rtl/smb_lw_lowtimer.sv
module smb_lw_lowtimer
   import smb_lw_pkg::*;
#(
   parameter int TMO_MS   = 25,
   parameter int RECOV_MS = 35,
   parameter int MS_W     = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_i,
   input  logic            tick_i,
   output logic [MS_W-1:0] ms_cnt_o,
   output smb_lw_evt_t     evt_o
);

   localparam logic [MS_W-1:0] TMO_PRE   = MS_W'(TMO_MS - 1);
   localparam logic [MS_W-1:0] RECOV_PRE = MS_W'(RECOV_MS - 1);
   localparam logic [MS_W-1:0] RECOV_LIM = MS_W'(RECOV_MS);

   logic [MS_W-1:0] ms_q;
   logic            step;

   assign step            = tick_i && !scl_i && (ms_q < RECOV_LIM);
   assign evt_o.hit_tmo   = step && (ms_q == TMO_PRE);
   assign evt_o.hit_recov = step && (ms_q == RECOV_PRE);
   assign ms_cnt_o        = ms_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ms_q <= '0;
      else if (scl_i)
         ms_q <= '0;
      else if (step)
         ms_q <= ms_q + 1'b1;
   end

   AST_MS_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      scl_i |=> (ms_cnt_o == '0)); // R2
   AST_MS_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_i) |=> (ms_cnt_o == $past(ms_cnt_o) || ms_cnt_o == $past(ms_cnt_o) + 1'b1)); // R3
   AST_MS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      ms_cnt_o <= RECOV_LIM); // R4

endmodule

// File: rtl/smb_lw_startdet.sv
module smb_lw_startdet (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign start_o = scl_q && scl_i && sda_q && !sda_i;

endmodule

// File: rtl/smb_lw_action.sv
module smb_lw_action
   import smb_lw_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  smb_lw_evt_t evt_i,
   input  smb_role_e   role_i,
   input  logic        clear_i,
   input  logic        start_i,
   output logic        flag_o,
   output logic        stop_req_o,
   output logic        slv_rst_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o     <= 1'b0;
         stop_req_o <= 1'b0;
         slv_rst_o  <= 1'b0;
      end else begin
         // a new timeout takes priority over a simultaneous clear
         if (evt_i.hit_tmo)
            flag_o <= 1'b1;
         else if (clear_i || start_i)
            flag_o <= 1'b0;
         stop_req_o <= (role_i == ROLE_MASTER) && (evt_i.hit_tmo || evt_i.hit_recov);
         slv_rst_o  <= (role_i == ROLE_SLAVE) && evt_i.hit_tmo;
      end
   end

   AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req_o |=> !stop_req_o); // R5
   AST_SLVRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      slv_rst_o |=> !slv_rst_o); // R7
   AST_ACTIONS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop_req_o && slv_rst_o)); // R7
   AST_SLVRST_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      slv_rst_o |-> flag_o); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clear_i && !start_i) |=> flag_o); // R8

endmodule

// File: rtl/smb_scl_lowwatch.sv
module smb_scl_lowwatch
   import smb_lw_pkg::*;
#(
   parameter int PRESC_W      = 17,
   parameter int TMO_MS       = 25,
   parameter int RECOV_MS     = 35,
   parameter bit START_CLEARS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic               master_mode_i,
   input  logic [PRESC_W-1:0] prescale_i,
   input  logic               tmo_clear_i,
   output logic               tmo_flag_o,
   output logic               stop_req_o,
   output logic               slv_rst_o
);

   localparam int MS_W = $clog2(RECOV_MS + 1);

   generate
      if (PRESC_W < 1 || PRESC_W > 32) begin : g_bad_presc
         $error("PRESC_W out of range");
      end
      if (TMO_MS < 1) begin : g_bad_tmo
         $error("TMO_MS must be at least 1");
      end
      if (RECOV_MS <= TMO_MS) begin : g_bad_recov
         $error("RECOV_MS must exceed TMO_MS");
      end
   endgenerate

   logic            tick;
   logic            start_det;
   logic [MS_W-1:0] ms_cnt;
   smb_lw_evt_t     evt;

   smb_lw_tick #(
      .PRESC_W (PRESC_W)
   ) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .prescale_i (prescale_i),
      .tick_o     (tick)
   );

   smb_lw_lowtimer #(
      .TMO_MS   (TMO_MS),
      .RECOV_MS (RECOV_MS),
      .MS_W     (MS_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .tick_i   (tick),
      .ms_cnt_o (ms_cnt),
      .evt_o    (evt)
   );

   generate
      if (START_CLEARS) begin : g_start
         smb_lw_startdet u_start (
            .clk     (clk),
            .rst_n   (rst_n),
            .scl_i   (scl_i),
            .sda_i   (sda_i),
            .start_o (start_det)
         );
      end else begin : g_nostart
         logic unused_sda;
         assign unused_sda = sda_i;
         assign start_det  = 1'b0;
      end
   endgenerate

   smb_lw_action u_action (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .role_i     (smb_role_e'(master_mode_i)),
      .clear_i    (tmo_clear_i),
      .start_i    (start_det),
      .flag_o     (tmo_flag_o),
      .stop_req_o (stop_req_o),
      .slv_rst_o  (slv_rst_o)
   );

   AST_NO_STOP_AS_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode_i && !$past(master_mode_i)) |-> !stop_req_o); // R7
   AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.hit_recov && !tmo_clear_i && !start_det) |=> tmo_flag_o); // R4

endmodule

// File: tb/tb_smb_scl_lowwatch.sv
`timescale 1ns/1ps
module tb_smb_scl_lowwatch;

   localparam int PW = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl = 1'b1;
   logic          sda = 1'b1;
   logic          master = 1'b0;
   logic [PW-1:0] presc = '0;
   logic          tclr = 1'b0;
   logic          flag, stopq, srst;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   smb_scl_lowwatch #(.PRESC_W(PW)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl),
      .sda_i         (sda),
      .master_mode_i (master),
      .prescale_i    (presc),
      .tmo_clear_i   (tclr),
      .tmo_flag_o    (flag),
      .stop_req_o    (stopq),
      .slv_rst_o     (srst)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // clock line held low; n counts low edges since the first low sample
   task automatic sweep(int p, bit m);
      int t25, t35;
      string tag;
      t25 = 25 * (p + 1);
      t35 = 35 * (p + 1);
      @(negedge clk);
      presc = PW'(p); master = m; scl = 1'b1; sda = 1'b1; tclr = 1'b1;
      @(negedge clk);
      tclr = 1'b0;
      repeat (2) @(negedge clk);
      scl = 1'b0;
      for (int n = 1; n <= 50 * (p + 1); n++) begin
         @(negedge clk);
         tag = (n > t35) ? "R4" : "R3";
         chk(tag, "flag", flag, n >= t25);
         chk(m ? ((n > t35) ? "R4" : ((n == t35) ? "R6" : "R5")) : "R7", "stop_req",
             stopq, m && (n == t25 || n == t35));
         chk((n > t35) ? "R4" : "R7", "slv_rst", srst, !m && (n == t25));
      end
      scl = 1'b1;
      repeat (5) @(negedge clk);
      chk("R8", "flag sticky after SCL high", flag, 1'b1);
      if (m) begin
         tclr = 1'b1;
         @(negedge clk);
         tclr = 1'b0;
         chk("R8", "flag after clear", flag, 1'b0);
      end else begin
         sda = 1'b0;
         @(negedge clk);
         chk("R9", "flag after START", flag, 1'b0);
         sda = 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "flag in reset", flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "flag", flag, 1'b0);
      chk("R1", "stop_req", stopq, 1'b0);
      chk("R1", "slv_rst", srst, 1'b0);

      for (int p = 0; p < 8; p++) begin
         sweep(p, 1'b1);
         sweep(p, 1'b0);
      end

      // R2: two near-threshold low phases split by a single high sample
      begin
         int thr;
         thr = 25 * 3;
         @(negedge clk);
         presc = PW'(2); master = 1'b1; scl = 1'b0;
         for (int n = 1; n < thr; n++) begin
            @(negedge clk);
            chk("R2", "flag first low phase", flag, 1'b0);
         end
         scl = 1'b1;
         @(negedge clk);
         scl = 1'b0;
         for (int n = 1; n < thr; n++) begin
            @(negedge clk);
            chk("R2", "flag second low phase", flag, 1'b0);
            chk("R2", "stop_req second low phase", stopq, 1'b0);
         end
         scl = 1'b1;
         @(negedge clk);
      end

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (190000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule